// File: doc/BRIEF.md
# Write-Update Line Coherence Controller

This block keeps the coherence state of a small set of cache lines for one snooping cache that runs a write-update protocol. It has no invalid state. A line whose tag matches always holds valid data. A separate per-line miss flag marks lines that have never been filled, or that were filled and then evicted. Every filled line is in one of four states:

- Exclusive: clean, and held only here.
- Shared-clean: possibly held by other caches as well.
- Shared-modified: dirty, and this cache owns the write-back while others may hold clean copies.
- Modified: dirty, and held only here.

The processor side presents one request per cycle: a read, a write, an eviction or a reserved no-op, on a line index. The bus side presents one snooped command per cycle on a line index. The shared-line input is sampled in the same cycle as the processor request that it qualifies. The block answers one cycle later with a bus request (command and line index), a write-back flag for dirty evictions, and a data-supply enable for snooped reads that hit an owned line.

A combinational query port returns the state and miss flag of any line. Data arrays, tag compare, arbitration and memory are outside the block.

Top module: `wupd_line_ctrl`

## Requirements
- R1: While reset is active and after it is released, every line has its miss flag at 1 and state Exclusive (code 0), and bus_vld, bus_wb and snp_supply are 0. Reset is asserted asynchronously and released on the second rising clock edge after rst_n goes high.
- R2: A processor read (op 0) on a line with its miss flag set gives, one cycle later, bus_vld=1 with bus_cmd READ (code 0) and bus_idx equal to the line. The miss flag clears. The line becomes Shared-clean (code 1) if shared_in was 1, else Exclusive (code 0).
- R3: A processor read on a filled line produces no bus request and leaves the state unchanged. Op code 3 has no effect at all.
- R4: A processor write (op 1) to a filled line in Exclusive or Modified (code 3) leaves it Modified with no bus request.
- R5: A processor write to a filled line in Shared-clean or Shared-modified (code 2) issues bus_cmd UPDATE (code 1). The line becomes Shared-modified if shared_in was 1, else Modified.
- R6: A processor write to a line with its miss flag set issues bus_cmd READ_UPDATE (code 3) and clears the miss flag. The line becomes Shared-modified if shared_in was 1, else Modified.
- R7: A snooped READ on a filled line moves Exclusive to Shared-clean and Modified to Shared-modified, and leaves the shared states unchanged. snp_supply is 1 on the following cycle exactly when the line was Modified or Shared-modified.
- R8: A snooped UPDATE or READ_UPDATE on a filled line moves it to Shared-clean. READ_UPDATE also raises snp_supply when the line was Modified or Shared-modified.
- R9: A snooped FLUSH (code 2), or any snoop on a line whose miss flag is set, changes nothing and raises no supply.
- R10: Evicting (op 2) a line in Modified or Shared-modified issues bus_cmd FLUSH with bus_wb=1. Evicting a line in Exclusive or Shared-clean issues no bus request. Evicting a line whose miss flag is set does nothing. After any eviction of a filled line, its miss flag is 1 and its state is Exclusive.
- R11: When a snoop and a processor request hit the same line in one cycle, the snoop transition is applied first and the processor request acts on its result.
- R12: qry_state and qry_miss show, combinationally, the state and miss flag of line qry_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_vld | input | 1 | Processor request valid |
| cpu_op | input | 2 | 0 read, 1 write, 2 evict, 3 no-op |
| cpu_idx | input | IDX_W | Processor line index |
| shared_in | input | 1 | Shared line sampled with the processor request |
| snp_vld | input | 1 | Snooped command valid |
| snp_cmd | input | 2 | 0 read, 1 update, 2 flush, 3 read-update |
| snp_idx | input | IDX_W | Snooped line index |
| qry_idx | input | IDX_W | Query line index |
| bus_vld | output | 1 | Bus request valid |
| bus_cmd | output | 2 | Bus command, same coding as snp_cmd |
| bus_idx | output | IDX_W | Line index of the bus request |
| bus_wb | output | 1 | Request is a dirty write-back |
| snp_supply | output | 1 | This cache supplies data for the snooped read |
| qry_state | output | 2 | State of the queried line |
| qry_miss | output | 1 | Miss flag of the queried line |

## Verification
A directed walk takes one line through every state in turn. It separates the clean-exclusive and owned-dirty paths, and it toggles the shared input to tell the shared and private outcomes apart on fills and on write updates. Snoops to unfilled lines and flush snoops show that ignored commands change nothing. A same-line collision shows that the snoop acts before the processor request. A long random phase over a few line indices with all opcodes then mixes collisions, evictions and refills, and every output and the queried state are compared each cycle against a behavioural model.

// File: rtl/wupd_pkg.sv
package wupd_pkg;
  typedef enum logic [1:0] {
    ST_EXCL  = 2'd0,
    ST_SHCLN = 2'd1,
    ST_SHMOD = 2'd2,
    ST_MOD   = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BC_READ    = 2'd0,
    BC_UPDATE  = 2'd1,
    BC_FLUSH   = 2'd2,
    BC_READUPD = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    CO_READ  = 2'd0,
    CO_WRITE = 2'd1,
    CO_EVICT = 2'd2,
    CO_NOP   = 2'd3
  } cpu_op_e;

  function automatic line_st_e pick_shared(input logic shr);
    return shr ? ST_SHMOD : ST_MOD;
  endfunction
endpackage

// File: rtl/wupd_next.sv
module wupd_next
  import wupd_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  line_st_e             st_q   [N],
  input  logic     [N-1:0]     miss_q,
  input  logic                 cpu_vld,
  input  cpu_op_e              cpu_op,
  input  logic     [IDX_W-1:0] cpu_idx,
  input  logic                 shr_in,
  input  logic                 snp_vld,
  input  bus_cmd_e             snp_cmd,
  input  logic     [IDX_W-1:0] snp_idx,
  output line_st_e             st_d   [N],
  output logic     [N-1:0]     miss_d,
  output logic     [N-1:0]     line_we,
  output logic                 bus_vld_d,
  output bus_cmd_e             bus_cmd_d,
  output logic                 wb_d,
  output logic                 supply_d
);
  line_st_e st_snp [N];

  for (genvar i = 0; i < N; i++) begin : g_line
    logic snp_hit, cpu_hit;
    assign snp_hit = snp_vld && (snp_idx == IDX_W'(i)) && !miss_q[i];
    assign cpu_hit = cpu_vld && (cpu_idx == IDX_W'(i));
    assign line_we[i] = snp_hit || cpu_hit;

    // snoop transition, applied first
    always_comb begin
      st_snp[i] = st_q[i];
      if (snp_hit) begin
        unique case (snp_cmd)
          BC_READ: begin
            if (st_q[i] == ST_EXCL) st_snp[i] = ST_SHCLN;
            else if (st_q[i] == ST_MOD) st_snp[i] = ST_SHMOD;
          end
          BC_UPDATE, BC_READUPD: st_snp[i] = ST_SHCLN;
          default: st_snp[i] = st_q[i];
        endcase
      end
    end

    // processor transition on the snooped result
    always_comb begin
      st_d[i]   = st_snp[i];
      miss_d[i] = miss_q[i];
      if (cpu_hit) begin
        unique case (cpu_op)
          CO_READ: begin
            if (miss_q[i]) begin
              miss_d[i] = 1'b0;
              st_d[i]   = shr_in ? ST_SHCLN : ST_EXCL;
            end
          end
          CO_WRITE: begin
            miss_d[i] = 1'b0;
            if (miss_q[i]) st_d[i] = pick_shared(shr_in);
            else if (st_snp[i] == ST_SHCLN || st_snp[i] == ST_SHMOD)
              st_d[i] = pick_shared(shr_in);
            else st_d[i] = ST_MOD;
          end
          CO_EVICT: begin
            if (!miss_q[i]) begin
              miss_d[i] = 1'b1;
              st_d[i]   = ST_EXCL;
            end
          end
          default: st_d[i] = st_snp[i];
        endcase
      end
    end
  end

  line_st_e snp_line_st;
  logic     snp_line_miss;
  line_st_e cpu_line_st;
  logic     cpu_line_miss;

  assign snp_line_st   = st_q[snp_idx];
  assign snp_line_miss = miss_q[snp_idx];
  assign cpu_line_st   = st_snp[cpu_idx];
  assign cpu_line_miss = miss_q[cpu_idx];

  always_comb begin
    supply_d = 1'b0;
    if (snp_vld && !snp_line_miss &&
        (snp_cmd == BC_READ || snp_cmd == BC_READUPD) &&
        (snp_line_st == ST_MOD || snp_line_st == ST_SHMOD))
      supply_d = 1'b1;
  end

  always_comb begin
    bus_vld_d = 1'b0;
    bus_cmd_d = BC_READ;
    wb_d      = 1'b0;
    if (cpu_vld) begin
      unique case (cpu_op)
        CO_READ: if (cpu_line_miss) bus_vld_d = 1'b1;
        CO_WRITE: begin
          if (cpu_line_miss) begin
            bus_vld_d = 1'b1;
            bus_cmd_d = BC_READUPD;
          end else if (cpu_line_st == ST_SHCLN || cpu_line_st == ST_SHMOD) begin
            bus_vld_d = 1'b1;
            bus_cmd_d = BC_UPDATE;
          end
        end
        CO_EVICT: begin
          if (!cpu_line_miss &&
              (cpu_line_st == ST_MOD || cpu_line_st == ST_SHMOD)) begin
            bus_vld_d = 1'b1;
            bus_cmd_d = BC_FLUSH;
            wb_d      = 1'b1;
          end
        end
        default: bus_vld_d = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/wupd_line_bank.sv
module wupd_line_bank
  import wupd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     line_we,
  input  line_st_e         st_d   [N],
  input  logic [N-1:0]     miss_d,
  output line_st_e         st_q   [N],
  output logic [N-1:0]     miss_q
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i]   <= ST_EXCL;
        miss_q[i] <= 1'b1;
      end else if (line_we[i]) begin
        st_q[i]   <= st_d[i];
        miss_q[i] <= miss_d[i];
      end
    end
  end
endmodule

// File: rtl/wupd_bus_reg.sv
module wupd_bus_reg
  import wupd_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_vld_d,
  input  bus_cmd_e         bus_cmd_d,
  input  logic [IDX_W-1:0] bus_idx_d,
  input  logic             wb_d,
  input  logic             supply_d,
  output logic             bus_vld_q,
  output bus_cmd_e         bus_cmd_q,
  output logic [IDX_W-1:0] bus_idx_q,
  output logic             wb_q,
  output logic             supply_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_vld_q <= 1'b0;
      wb_q      <= 1'b0;
      supply_q  <= 1'b0;
    end else begin
      bus_vld_q <= bus_vld_d;
      wb_q      <= wb_d;
      supply_q  <= supply_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_cmd_q <= BC_READ;
      bus_idx_q <= '0;
    end else if (bus_vld_d) begin
      bus_cmd_q <= bus_cmd_d;
      bus_idx_q <= bus_idx_d;
    end
  end
endmodule

// File: rtl/wupd_line_ctrl.sv
module wupd_line_ctrl
  import wupd_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_vld,
  input  logic [1:0]       cpu_op,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic             shared_in,
  input  logic             snp_vld,
  input  logic [1:0]       snp_cmd,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [IDX_W-1:0] qry_idx,
  output logic             bus_vld,
  output logic [1:0]       bus_cmd,
  output logic [IDX_W-1:0] bus_idx,
  output logic             bus_wb,
  output logic             snp_supply,
  output logic [1:0]       qry_state,
  output logic             qry_miss
);
  logic rst_meta_n, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  line_st_e               st_q   [NUM_LINES];
  line_st_e               st_d   [NUM_LINES];
  logic [NUM_LINES-1:0]   miss_q, miss_d, line_we;
  logic                   bus_vld_d, wb_d, supply_d;
  bus_cmd_e               bus_cmd_d, bus_cmd_q;
  logic                   cpu_line_miss;

  assign cpu_line_miss = miss_q[cpu_idx];

  wupd_next #(.N(NUM_LINES), .IDX_W(IDX_W)) u_next (
    .st_q      (st_q),
    .miss_q    (miss_q),
    .cpu_vld   (cpu_vld),
    .cpu_op    (cpu_op_e'(cpu_op)),
    .cpu_idx   (cpu_idx),
    .shr_in    (shared_in),
    .snp_vld   (snp_vld),
    .snp_cmd   (bus_cmd_e'(snp_cmd)),
    .snp_idx   (snp_idx),
    .st_d      (st_d),
    .miss_d    (miss_d),
    .line_we   (line_we),
    .bus_vld_d (bus_vld_d),
    .bus_cmd_d (bus_cmd_d),
    .wb_d      (wb_d),
    .supply_d  (supply_d)
  );

  wupd_line_bank #(.N(NUM_LINES)) u_bank (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .line_we (line_we),
    .st_d    (st_d),
    .miss_d  (miss_d),
    .st_q    (st_q),
    .miss_q  (miss_q)
  );

  wupd_bus_reg #(.IDX_W(IDX_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_vld_d (bus_vld_d),
    .bus_cmd_d (bus_cmd_d),
    .bus_idx_d (cpu_idx),
    .wb_d      (wb_d),
    .supply_d  (supply_d),
    .bus_vld_q (bus_vld),
    .bus_cmd_q (bus_cmd_q),
    .bus_idx_q (bus_idx),
    .wb_q      (bus_wb),
    .supply_q  (snp_supply)
  );

  assign bus_cmd   = bus_cmd_q;
  assign qry_state = st_q[qry_idx];
  assign qry_miss  = miss_q[qry_idx];
endmodule

// File: rtl/wupd_line_chk.sv
module wupd_line_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_vld,
  input logic [1:0] cpu_op,
  input logic       cpu_line_miss,
  input logic       snp_vld,
  input logic [1:0] snp_cmd,
  input logic       bus_vld,
  input logic [1:0] bus_cmd,
  input logic       bus_wb,
  input logic       snp_supply
);
  AST_MISS_READ_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_vld && cpu_op == 2'd0 && cpu_line_miss) |=> (bus_vld && bus_cmd == 2'd0)); // R2

  AST_HIT_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_vld && cpu_op == 2'd0 && !cpu_line_miss) |=> !bus_vld); // R3

  AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_vld || cpu_op == 2'd3) |=> !bus_vld); // R3

  AST_WRITE_MISS_RDUPD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_vld && cpu_op == 2'd1 && cpu_line_miss) |=> (bus_vld && bus_cmd == 2'd3)); // R6

  AST_WB_IS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wb |-> (bus_vld && bus_cmd == 2'd2)); // R10

  AST_SUPPLY_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> $past(snp_vld && (snp_cmd == 2'd0 || snp_cmd == 2'd3))); // R7
endmodule

bind wupd_line_ctrl wupd_line_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .cpu_vld       (cpu_vld),
  .cpu_op        (cpu_op),
  .cpu_line_miss (cpu_line_miss),
  .snp_vld       (snp_vld),
  .snp_cmd       (snp_cmd),
  .bus_vld       (bus_vld),
  .bus_cmd       (bus_cmd),
  .bus_wb        (bus_wb),
  .snp_supply    (snp_supply)
);

// File: tb/wupd_line_ctrl_tb.sv
`timescale 1ns/1ps
module wupd_line_ctrl_tb;
  localparam int NL = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          cpu_vld, shared_in, snp_vld;
  logic [1:0]    cpu_op, snp_cmd;
  logic [IW-1:0] cpu_idx, snp_idx, qry_idx;
  logic          bus_vld, bus_wb, snp_supply, qry_miss;
  logic [1:0]    bus_cmd, qry_state;
  logic [IW-1:0] bus_idx;

  wupd_line_ctrl #(.NUM_LINES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_vld(cpu_vld), .cpu_op(cpu_op),
    .cpu_idx(cpu_idx), .shared_in(shared_in), .snp_vld(snp_vld),
    .snp_cmd(snp_cmd), .snp_idx(snp_idx), .qry_idx(qry_idx),
    .bus_vld(bus_vld), .bus_cmd(bus_cmd), .bus_idx(bus_idx),
    .bus_wb(bus_wb), .snp_supply(snp_supply),
    .qry_state(qry_state), .qry_miss(qry_miss)
  );

  // behavioural reference: 0 E, 1 Sc, 2 Sm, 3 M
  int    m_st   [NL];
  bit    m_miss [NL];
  int    rs_cnt;
  bit    e_vld, e_wb, e_sup;
  int    e_cmd, e_idx;
  string bus_tag, sup_tag;
  int    checks, errors;
  bit    done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || rs_cnt < 2) begin
      if (!rst_n) rs_cnt = 0; else rs_cnt++;
      foreach (m_st[k]) begin m_st[k] = 0; m_miss[k] = 1; end
      e_vld = 0; e_wb = 0; e_sup = 0; e_cmd = 0; e_idx = 0;
      bus_tag = "R1"; sup_tag = "R1";
    end else begin
      int s, c;
      bit clash;
      e_sup = 0; sup_tag = "R9";
      clash = snp_vld && cpu_vld && (snp_idx == cpu_idx);
      if (snp_vld && !m_miss[snp_idx]) begin
        s = m_st[snp_idx];
        case (snp_cmd)
          0: begin
            sup_tag = "R7";
            e_sup = (s == 3 || s == 2);
            if (s == 0) m_st[snp_idx] = 1;
            if (s == 3) m_st[snp_idx] = 2;
          end
          1: begin sup_tag = "R8"; m_st[snp_idx] = 1; end
          3: begin sup_tag = "R8"; e_sup = (s == 3 || s == 2); m_st[snp_idx] = 1; end
          default: ;
        endcase
      end
      e_vld = 0; e_wb = 0; bus_tag = "R3";
      if (cpu_vld) begin
        c = cpu_idx; s = m_st[c];
        case (cpu_op)
          0: if (m_miss[c]) begin
               bus_tag = "R2"; e_vld = 1; e_cmd = 0; e_idx = c;
               m_miss[c] = 0; m_st[c] = shared_in ? 1 : 0;
             end
          1: if (m_miss[c]) begin
               bus_tag = "R6"; e_vld = 1; e_cmd = 3; e_idx = c;
               m_miss[c] = 0; m_st[c] = shared_in ? 2 : 3;
             end else if (s == 1 || s == 2) begin
               bus_tag = "R5"; e_vld = 1; e_cmd = 1; e_idx = c;
               m_st[c] = shared_in ? 2 : 3;
             end else begin
               bus_tag = "R4"; m_st[c] = 3;
             end
          2: begin
               bus_tag = "R10";
               if (!m_miss[c]) begin
                 if (s == 3 || s == 2) begin e_vld = 1; e_wb = 1; e_cmd = 2; e_idx = c; end
                 m_miss[c] = 1; m_st[c] = 0;
               end
             end
          default: bus_tag = "R3";
        endcase
        if (clash) bus_tag = {bus_tag, "/R11"};
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (bus_vld !== e_vld || bus_wb !== e_wb ||
          (e_vld && (bus_cmd !== 2'(e_cmd) || bus_idx !== IW'(e_idx)))) begin
        errors++;
        $display("FAIL %s bus: vld=%0b cmd=%0d idx=%0d wb=%0b expected vld=%0b cmd=%0d idx=%0d wb=%0b",
                 bus_tag, bus_vld, bus_cmd, bus_idx, bus_wb, e_vld, e_cmd, e_idx, e_wb);
      end
      checks++;
      if (snp_supply !== e_sup) begin
        errors++;
        $display("FAIL %s supply: got %0b expected %0b", sup_tag, snp_supply, e_sup);
      end
      checks++;
      if (qry_state !== 2'(m_st[qry_idx]) || qry_miss !== m_miss[qry_idx]) begin
        errors++;
        $display("FAIL R12 query line %0d: state=%0d miss=%0b expected state=%0d miss=%0b",
                 qry_idx, qry_state, qry_miss, m_st[qry_idx], m_miss[qry_idx]);
      end
    end
  end

  task automatic cyc(input bit cv, input int op, input int ci, input bit sh,
                     input bit sv, input int sc, input int si, input int qi);
    cpu_vld = cv; cpu_op = 2'(op); cpu_idx = IW'(ci); shared_in = sh;
    snp_vld = sv; snp_cmd = 2'(sc); snp_idx = IW'(si); qry_idx = IW'(qi);
    @(negedge clk);
  endtask

  task automatic idle(input int qi);
    cyc(0, 0, 0, 0, 0, 0, 0, qi);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0; rs_cnt = 0;
    rst_n = 1'b0;
    cpu_vld = 0; cpu_op = 0; cpu_idx = 0; shared_in = 0;
    snp_vld = 0; snp_cmd = 0; snp_idx = 0; qry_idx = 0;
    // R1: reset state seen through query and outputs
    for (int k = 0; k < NL; k++) begin qry_idx = IW'(k); @(negedge clk); end
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) idle(k);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);   // R2 read miss, private -> E
    cyc(1, 0, 0, 1, 0, 0, 0, 0);   // R3 read hit
    cyc(1, 1, 0, 0, 0, 0, 0, 0);   // R4 E -> M
    cyc(1, 1, 0, 1, 0, 0, 0, 0);   // R4 M stays
    cyc(0, 0, 0, 0, 1, 0, 0, 0);   // R7 snoop read, M -> Sm, supply
    cyc(0, 0, 0, 0, 1, 0, 0, 0);   // R7 Sm stays, supply
    cyc(1, 1, 0, 1, 0, 0, 0, 0);   // R5 Sm, shared -> Sm
    cyc(0, 0, 0, 0, 1, 1, 0, 0);   // R8 snoop update -> Sc
    cyc(1, 1, 0, 0, 0, 0, 0, 0);   // R5 Sc, private -> M
    cyc(1, 2, 0, 0, 0, 0, 0, 0);   // R10 evict M, write-back
    cyc(1, 1, 1, 1, 0, 0, 0, 1);   // R6 write miss, shared -> Sm
    cyc(0, 0, 0, 0, 1, 2, 1, 1);   // R9 snoop flush ignored
    cyc(0, 0, 0, 0, 1, 0, 2, 2);   // R9 snoop on unfilled line
    cyc(0, 0, 0, 0, 1, 3, 1, 1);   // R8 read-update from Sm, supply, -> Sc
    cyc(1, 0, 3, 1, 0, 0, 0, 3);   // R2 read miss, shared -> Sc
    cyc(1, 2, 3, 0, 0, 0, 0, 3);   // R10 evict Sc silent
    cyc(1, 2, 3, 0, 0, 0, 0, 3);   // R10 evict unfilled, nothing
    cyc(1, 3, 1, 1, 0, 0, 0, 1);   // R3 no-op
    cyc(1, 0, 4, 0, 0, 0, 0, 4);   // fill line 4 -> E
    cyc(1, 1, 4, 1, 1, 0, 4, 4);   // R11 snoop read E->Sc then write -> update, Sm
    idle(4);
    for (int n = 0; n < 4000; n++) begin
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 3),
          $urandom_range(0, 1), $urandom_range(0, 2) != 0, $urandom_range(0, 3),
          $urandom_range(0, 3), $urandom_range(0, NL - 1));
    end
    idle(0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule